// File: doc/BRIEF.md
# Chip-Selected Configuration Register Slave

This block is a two-wire serial slave that gives a host read and write access to a small bank of 8-bit configuration registers. The clock line and the data line are oversampled with the system clock: each passes through a two-stage synchroniser, and edges and bus conditions are decoded from the synchronised copies. The slave never drives the data line high. It only pulls it low through an open-drain enable, for acknowledge bits and for zero data bits.

The slave takes part in bus traffic only while its active-high select input is high. Several identical devices can therefore share one fixed bus address, with the host picking one by its select line. A write carries the device address, a register index and one data byte. A read sends the register index first, then uses a repeated START and the read form of the address byte, and the slave returns one byte. A bus-idle detector watches how long both lines stay high. When the count runs past a limit, it forces the transfer logic back to its idle state.

Top module: `cfg_port_slave`

## Requirements
- R1: While `cs_en` is low the slave never pulls SDA low, and a complete write sent in that time leaves every register unchanged.
- R2: The device address is 7'b1010111. The byte 8'hAE (write) and the byte 8'hAF (read) are both acknowledged: the slave holds SDA low during the ninth clock.
- R3: An address byte that does not match is not acknowledged. SDA stays released for that byte and for every later byte until the next START or STOP, and registers are unchanged.
- R4: A write (START, 8'hAE, index, data, STOP) gets an acknowledge on all three bytes. The data byte is stored in the indexed register.
- R5: A read (START, 8'hAE, index, repeated START, 8'hAF) returns the indexed register's 8 bits MSB first. SDA is then released for the host's NACK.
- R6: With the default parameters, registers 6 and 7 are read-only (read-only mask 8'hC0) and hold 8'hC6 and 8'hC7. Indexes 8 and above are not implemented. Writes to either kind are acknowledged but change nothing. Reads of unimplemented indexes return 8'h00.
- R7: The SDA enable changes only in the system-clock cycle after a synchronised SCK falling edge, so it never changes while SCK is high.
- R8: `bus_idle` rises once both lines have been high for more than TBUF_CYC cycles since a STOP, or for more than THIGH_CYC cycles in any case. It is cleared by a START.
- R9: A bus-idle timeout in the middle of a byte returns the slave to idle, so the rest of that byte is not acknowledged.
- R10: Dropping `cs_en` during a transfer releases SDA and abandons the transfer, and a partly received data byte is not written.
- R11: A START or STOP seen in any state resynchronises the slave. A STOP inside a data byte discards it, and a START inside a byte begins a new address byte.
- R12: After reset SDA is released, `bus_idle` is low, and the registers hold their reset values: 8'h00 for the writable ones and 8'hC6/8'hC7 for the read-only ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_en | input | 1 | Active-high select; low makes the slave deaf and silent |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| bus_idle | output | 1 | Bus-idle detected by the high-time counters |

## Verification
The bench builds the block with TBUF_CYC of 20 and THIGH_CYC of 60, so both idle paths are reached within a few dozen cycles. The gap after a STOP trips the short limit, and a clock held high in the middle of an address byte trips the long one. The default bank of eight registers with mask 8'hC0 is kept, so the read-only registers and an unimplemented index (8'h20) are reached with ordinary transfers. Bit phases last eight system clocks, which leaves room for the three-cycle input delay before each SCK edge the host makes.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam logic [6:0] DEV_ADDR = 7'b1010111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_REG,
        ST_WDATA,
        ST_TX,
        ST_HOLD
    } xfer_st_e;

    typedef enum logic [1:0] {
        NX_REG,
        NX_WDATA,
        NX_TX,
        NX_HOLD
    } ack_next_e;

    typedef struct packed {
        xfer_st_e  st;
        ack_next_e nxt;
        logic [3:0] bits;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       oe;
    } xfer_s;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // bit 0 carries the clock line, bit 1 the data line
    typedef struct packed {
        logic [1:0] m1;
        logic [1:0] m2;
        logic [1:0] pv;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.m1 = {sda_in, scl_in};
        s_d.m2 = s_q.m1;
        s_d.pv = s_q.m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{m1: 2'b11, m2: 2'b11, pv: 2'b11};
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.m2[0];
    assign sda_s     = s_q.m2[1];
    assign scl_rise  = s_q.m2[0] & ~s_q.pv[0];
    assign scl_fall  = ~s_q.m2[0] & s_q.pv[0];
    assign start_det = s_q.m2[0] & s_q.pv[0] & s_q.pv[1] & ~s_q.m2[1];
    assign stop_det  = s_q.m2[0] & s_q.pv[0] & ~s_q.pv[1] & s_q.m2[1];
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
    parameter int TBUF_CYC  = 235,
    parameter int THIGH_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic start_det,
    input  logic stop_det,
    output logic bus_idle
);
    localparam int LIMIT = ((THIGH_CYC > TBUF_CYC) ? THIGH_CYC : TBUF_CYC) + 1;
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stop_seen;
        logic             idle;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (scl_s && sda_s) begin
            if (t_q.cnt != CNT_W'(LIMIT)) t_d.cnt = t_q.cnt + 1'b1;
        end else begin
            t_d.cnt = '0;
        end
        if (start_det) begin
            t_d.stop_seen = 1'b0;
            t_d.idle      = 1'b0;
        end else begin
            if (stop_det) t_d.stop_seen = 1'b1;
            if ((t_q.stop_seen && (t_q.cnt > CNT_W'(TBUF_CYC))) ||
                (t_q.cnt > CNT_W'(THIGH_CYC)))
                t_d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_idle = t_q.idle;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                      NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0]     RO_MASK  = '0,
    parameter logic [NUM_REGS*8-1:0]   RST_VALS = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [7:0]              rd_addr,
    output logic [7:0]              rd_data,
    output logic [NUM_REGS*8-1:0]   regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (RO_MASK[i]) begin : g_ro
            assign regs_flat[i*8 +: 8] = RST_VALS[i*8 +: 8];
        end else begin : g_rw
            logic [7:0] r_d, r_q;
            always_comb begin
                r_d = r_q;
                if (wr_en && (wr_addr == 8'(i))) r_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= RST_VALS[i*8 +: 8];
                else        r_q <= r_d;
            end
            assign regs_flat[i*8 +: 8] = r_q;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == 8'(i)) rd_data = regs_flat[i*8 +: 8];
        end
    end
endmodule

// File: rtl/cfg_port_slave.sv
module cfg_port_slave
    import smb_cfg_pkg::*;
#(
    parameter int                    NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0]   RO_MASK   = 8'hC0,
    parameter logic [NUM_REGS*8-1:0] RST_VALS  = 64'hC7C6_0000_0000_0000,
    parameter int                    TBUF_CYC  = 235,
    parameter int                    THIGH_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_en,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    output logic bus_idle
);
    localparam int BANK_W = NUM_REGS * 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [7:0] rd_data;
    logic [BANK_W-1:0] regs_flat;

    xfer_s c_d, c_q;

    smb_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_idle_timer #(
        .TBUF_CYC  (TBUF_CYC),
        .THIGH_CYC (THIGH_CYC)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_idle  (bus_idle)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .RO_MASK  (RO_MASK),
        .RST_VALS (RST_VALS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (c_q.ptr),
        .wr_data   (c_q.sh),
        .rd_addr   (c_q.ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    always_comb begin
        c_d   = c_q;
        wr_en = 1'b0;
        if (!cs_en) begin
            c_d.st   = ST_IDLE;
            c_d.oe   = 1'b0;
            c_d.bits = '0;
        end else if (start_det) begin
            c_d.st   = ST_ADDR;
            c_d.oe   = 1'b0;
            c_d.bits = '0;
        end else if (stop_det || bus_idle) begin
            c_d.st   = ST_IDLE;
            c_d.oe   = 1'b0;
            c_d.bits = '0;
        end else begin
            case (c_q.st)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && (c_q.bits != 4'd8)) begin
                        c_d.sh   = {c_q.sh[6:0], sda_s};
                        c_d.bits = c_q.bits + 4'd1;
                    end else if (scl_fall && (c_q.bits == 4'd8)) begin
                        c_d.bits = '0;
                        if (c_q.st == ST_ADDR) begin
                            if (c_q.sh[7:1] == DEV_ADDR) begin
                                c_d.st  = ST_ACK;
                                c_d.oe  = 1'b1;
                                c_d.nxt = c_q.sh[0] ? NX_TX : NX_REG;
                            end else begin
                                c_d.st = ST_HOLD;
                            end
                        end else if (c_q.st == ST_REG) begin
                            c_d.ptr = c_q.sh;
                            c_d.st  = ST_ACK;
                            c_d.oe  = 1'b1;
                            c_d.nxt = NX_WDATA;
                        end else begin
                            wr_en   = 1'b1;
                            c_d.st  = ST_ACK;
                            c_d.oe  = 1'b1;
                            c_d.nxt = NX_HOLD;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise) begin
                        c_d.bits = 4'd1;
                    end else if (scl_fall && (c_q.bits == 4'd1)) begin
                        c_d.bits = '0;
                        c_d.oe   = 1'b0;
                        case (c_q.nxt)
                            NX_REG:   c_d.st = ST_REG;
                            NX_WDATA: c_d.st = ST_WDATA;
                            NX_TX: begin
                                c_d.st = ST_TX;
                                c_d.sh = rd_data;
                                c_d.oe = ~rd_data[7];
                            end
                            default:  c_d.st = ST_HOLD;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        c_d.bits = c_q.bits + 4'd1;
                    end else if (scl_fall && (c_q.bits != 4'd0)) begin
                        if (c_q.bits == 4'd8) begin
                            c_d.oe   = 1'b0;
                            c_d.st   = ST_HOLD;
                            c_d.bits = '0;
                        end else begin
                            c_d.sh = {c_q.sh[6:0], 1'b0};
                            c_d.oe = ~c_q.sh[6];
                        end
                    end
                end
                default: c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, nxt: NX_HOLD, bits: '0, sh: '0, ptr: '0, oe: 1'b0};
        else        c_q <= c_d;
    end

    assign sda_oe = c_q.oe;
endmodule

// File: rtl/cfg_port_slave_chk.sv
module cfg_port_slave_chk #(
    parameter int                  NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] RO_MASK  = 8'hC0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_en,
    input logic                  sda_oe,
    input logic                  bus_idle,
    input logic                  scl_s,
    input logic                  sda_s,
    input logic                  scl_fall,
    input logic                  wr_en,
    input logic [NUM_REGS*8-1:0] regs_flat
);
    assert_cs_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_en |=> !sda_oe);

    assert_drive_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> ($past(scl_fall) && !scl_s));

    assert_idle_needs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_idle) |-> $past(scl_s && sda_s));

    assert_commit_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ro_chk
        if (RO_MASK[i]) begin : g_on
            assert_ro_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(regs_flat[i*8 +: 8]));
        end
    end
endmodule

bind cfg_port_slave cfg_port_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .RO_MASK  (RO_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_en     (cs_en),
    .sda_oe    (sda_oe),
    .bus_idle  (bus_idle),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_fall  (scl_fall),
    .wr_en     (wr_en),
    .regs_flat (regs_flat)
);

// File: tb/cfg_port_slave_bench.sv
module cfg_port_slave_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_en = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe, bus_idle;
    wire  sda_line = sda_h & ~sda_oe;

    always #10 clk = ~clk;

    cfg_port_slave #(.TBUF_CYC(20), .THIGH_CYC(60)) u_cfg_port_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_en    (cs_en),
        .scl_in   (scl_h),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .bus_idle (bus_idle)
    );

    // scoreboard
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;

    always @(negedge clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            int e, o;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            o = obs_q.pop_front();
            compared++;
            if (e != o) begin
                mismatched++;
                $display("FAIL %s: actual %0h expected %0h", t, o, e);
            end
        end
    end

    // line monitors for R7 and R1
    int  oe_high_viol = 0;
    int  cs_viol = 0;
    logic scl_p = 1'b1, oe_p = 1'b0, cs_p = 1'b1;
    always @(posedge clk) begin
        if (rst_n) begin
            if (scl_h && scl_p && (sda_oe != oe_p)) oe_high_viol++;
            if (!cs_en && !cs_p && sda_oe) cs_viol++;
        end
        scl_p = scl_h;
        oe_p  = sda_oe;
        cs_p  = cs_en;
    end

    task automatic expect_v(input string t, input int v);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic observe(input int v);
        obs_q.push_back(v);
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; half();
        scl_h = 1'b1; half();
        sda_h = 1'b0; half();
        scl_h = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; half();
        scl_h = 1'b1; half();
        sda_h = 1'b1; half();
    endtask

    task automatic put_bit(input logic b);
        sda_h = b; half();
        scl_h = 1'b1; half();
        scl_h = 1'b0; half();
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; half();
        scl_h = 1'b1; half();
        b = sda_line;
        scl_h = 1'b0; half();
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
    endtask

    task automatic ack_step(input string t, input int e);
        logic b;
        expect_v(t, e);
        get_bit(b);
        observe(int'(b));
    endtask

    task automatic wr(input logic [7:0] ra, input logic [7:0] v, input int ack_e, input string t);
        bus_start();
        put_byte(8'hAE); ack_step({t, " addr ack"}, ack_e);
        put_byte(ra);    ack_step({t, " index ack"}, ack_e);
        put_byte(v);     ack_step({t, " data ack"}, ack_e);
        bus_stop();
    endtask

    task automatic rd(input logic [7:0] ra, input logic [7:0] ev, input string t);
        logic [7:0] v;
        bus_start();
        put_byte(8'hAE); ack_step({t, " R2 write-addr ack"}, 0);
        put_byte(ra);    ack_step({t, " index ack"}, 0);
        bus_start();
        put_byte(8'hAF); ack_step({t, " R2 read-addr ack"}, 0);
        expect_v({t, " read data"}, int'(ev));
        get_byte(v);
        observe(int'(v));
        put_bit(1'b1);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_v("R12 sda_oe after reset", 0);   observe(int'(sda_oe));
        expect_v("R12 bus_idle after reset", 0); observe(int'(bus_idle));
        repeat (70) @(negedge clk);
        expect_v("R8 idle after long high time", 1); observe(int'(bus_idle));

        rd(8'h07, 8'hC7, "R12 ro reset");
        rd(8'h00, 8'h00, "R12 rw reset");

        wr(8'h01, 8'h11, 0, "R4 R2 write");
        rd(8'h01, 8'h11, "R5 R4 readback");
        wr(8'h00, 8'h81, 0, "R4 write");
        rd(8'h00, 8'h81, "R5 msb first");
        wr(8'h02, 8'h5A, 0, "R4 write");
        rd(8'h02, 8'h5A, "R5 R4 readback");

        wr(8'h06, 8'h00, 0, "R6 ro write");
        rd(8'h06, 8'hC6, "R6 ro unchanged");
        wr(8'h20, 8'h99, 0, "R6 unimpl write");
        rd(8'h20, 8'h00, "R6 unimpl read");

        // R8: short limit after a STOP
        repeat (24) @(negedge clk);
        expect_v("R8 idle after stop", 1); observe(int'(bus_idle));

        // R3: wrong address, nothing acked, nothing written
        bus_start();
        expect_v("R8 idle cleared by start", 0); observe(int'(bus_idle));
        put_byte(8'hA4); ack_step("R3 addr nack", 1);
        put_byte(8'h01); ack_step("R3 index nack", 1);
        put_byte(8'h77); ack_step("R3 data nack", 1);
        bus_stop();
        rd(8'h01, 8'h11, "R3 reg untouched");

        // R1: deselected write
        cs_en = 1'b0;
        wr(8'h01, 8'h55, 1, "R1 deselected");
        cs_en = 1'b1;
        rd(8'h01, 8'h11, "R1 reg untouched");
        expect_v("R1 sda_oe while deselected", 0); observe(cs_viol);

        // R10: drop select inside data byte
        bus_start();
        put_byte(8'hAE); ack_step("R10 addr ack", 0);
        put_byte(8'h02); ack_step("R10 index ack", 0);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        cs_en = 1'b0; half(); cs_en = 1'b1; half();
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        ack_step("R10 no ack after abort", 1);
        bus_stop();
        rd(8'h02, 8'h5A, "R10 no partial write");

        // R10: drop select while slave holds ACK low
        bus_start();
        put_byte(8'hAE);
        sda_h = 1'b1; half();
        expect_v("R10 ack held before abort", 0); observe(int'(sda_line));
        cs_en = 1'b0;
        repeat (2) @(negedge clk);
        expect_v("R10 sda released", 1); observe(int'(sda_line));
        cs_en = 1'b1;
        scl_h = 1'b1; half(); scl_h = 1'b0; half();
        bus_stop();

        // R11: STOP inside data byte
        bus_start();
        put_byte(8'hAE); ack_step("R11 addr ack", 0);
        put_byte(8'h03); ack_step("R11 index ack", 0);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        rd(8'h03, 8'h00, "R11 stop discards byte");

        // R11: START inside data byte
        bus_start();
        put_byte(8'hAE); ack_step("R11 addr ack", 0);
        put_byte(8'h04); ack_step("R11 index ack", 0);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte(8'hAE); ack_step("R11 restart addr ack", 0);
        put_byte(8'h04); ack_step("R11 restart index ack", 0);
        put_byte(8'h3C); ack_step("R11 restart data ack", 0);
        bus_stop();
        rd(8'h04, 8'h3C, "R11 restart write");

        // R9: clock held high inside address byte
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        sda_h = 1'b1; half();
        scl_h = 1'b1;
        repeat (80) @(negedge clk);
        expect_v("R9 R8 idle during stuck clock", 1); observe(int'(bus_idle));
        scl_h = 1'b0; half();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        ack_step("R9 no ack after timeout", 1);
        bus_stop();
        rd(8'h05, 8'h00, "R9 slave usable again");

        expect_v("R7 sda_oe change while SCK high", 0); observe(oe_high_viol);

        repeat (4) @(negedge clk);
        if (exp_q.size() != obs_q.size()) begin
            mismatched++;
            $display("FAIL scoreboard: actual %0d observed expected %0d", obs_q.size(), exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule